// File: doc/BRIEF.md
# Parallel-Port IDE Register Access Sequencer

This block performs a single IDE register read or write through a standard parallel port running in 4-bit or 8-bit mode. It replaces the host software that used to wiggle the port registers by hand. Each access begins with an address phase. That phase latches an index byte into the adapter using fixed control-port strobe bursts. A data phase follows. A write sends the value twice. A 4-bit read samples the upper half of the status lines twice and joins the two halves into a byte. An 8-bit read turns the data lines around and samples a full byte.

Every update of the data or control register is one step of a fixed step program. Each step is held for a programmable number of clock cycles, so the access can be slowed to suit slow adapters. A caller starts an access with a one-cycle request. The caller then waits for the completion pulse. Requests that arrive while an access is running are dropped.

Top module: `nib_ide_seq`

## Requirements
- R1: The index byte driven in the address phase equals reg_i*4 + 1 + sel_i. For example, reg 7 with sel 1 gives 0x1E.
- R2: Strobe burst A drives control values 0x05,0x0D,0x05,0x0D,0x05,0x04 in that order. Strobe burst B drives 0x05,0x07,0x05,0x04. No other control value appears except the read values 0x06 and 0x26.
- R3: The address phase has 19 steps: data 0x01, then burst A, then data index, then burst B, then data 0x00, then burst A.
- R4: A 4-bit read (mode_i=0) follows the address phase with these 10 control steps: 0x06, sample, 0x04, 0x06, sample, 0x04, 0x06, 0x04, 0x06, 0x04. Each sample step reads stat_i.
- R5: The result of a 4-bit read is {second_sample[7:4], first_sample[7:4]}.
- R6: An 8-bit read (mode_i=1) follows the address phase with 5 steps: 0x26, sample pdata_i, 0x04, 0x26, 0x04. The result is the sampled byte.
- R7: A write, in either mode, follows the address phase with: data wdata_i, burst B, data wdata_i, burst B.
- R8: Every step, including a sample step, holds its port values for hold_i+1 clock cycles. hold_i is captured when the request is accepted.
- R9: busy_o is high from the cycle after acceptance until the last step ends. done_o is then high for exactly one cycle, with busy_o low.
- R10: A request while busy_o is high is ignored. The running access is unchanged, and no access follows it.
- R11: In reset and while idle after reset, pctrl_o is 0x04. After reset, pdata_o, rdata_o, busy_o and done_o are 0.
- R12: rdata_o changes only when a read completes. A write leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start pulse, accepted when idle |
| wr_i | input | 1 | 1 = register write, 0 = register read |
| sel_i | input | 1 | 0 = register file, 1 = command set |
| reg_i | input | 3 | IDE register number |
| wdata_i | input | 8 | Value for a write |
| mode_i | input | 1 | 0 = 4-bit reads, 1 = 8-bit reads |
| hold_i | input | HOLD_W | Extra cycles each step is held |
| stat_i | input | 8 | Port status lines |
| pdata_i | input | 8 | Port data lines, read back |
| pdata_o | output | 8 | Port data register |
| pctrl_o | output | 8 | Port control register |
| rdata_o | output | 8 | Byte from the last read |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The bench plays the role of the adapter. It serves a different status value on each entry into control 0x06, and a valid data byte only on the first entry into 0x26. A design that samples in the wrong phase, or swaps the two nibbles, therefore returns a wrong byte. The bench also compares the port values in every cycle against a step list it builds itself, across all register numbers, selects, modes, directions and three hold settings. A wrong strobe value, a wrong index offset or an off-by-one hold count therefore shows up as a sequence mismatch. Stray requests are injected mid-access to catch a design that restarts or queues them.

// File: rtl/nibseq_pkg.sv
package nibseq_pkg;
  typedef enum logic [1:0] {K_DATA, K_CTRL, K_SAMP_A, K_SAMP_B} step_kind_e;

  typedef struct packed {
    step_kind_e  kind;
    logic [7:0]  val;
  } step_t;

  localparam int ADDR_LEN = 19;
  localparam int TAIL_WR  = 10;
  localparam int TAIL_RD4 = 10;
  localparam int TAIL_RD8 = 5;
  localparam int MAX_LEN  = ADDR_LEN + TAIL_WR;
  localparam int STEP_W   = $clog2(MAX_LEN + 1);

  localparam logic [7:0] CTRL_REST  = 8'h04;
  localparam logic [7:0] CTRL_NIB   = 8'h06;
  localparam logic [7:0] CTRL_BYTE  = 8'h26;

  // strobe burst A (6 steps)
  function automatic logic [7:0] burst_a(input int j);
    case (j)
      0, 2, 4: burst_a = 8'h05;
      1, 3:    burst_a = 8'h0D;
      default: burst_a = 8'h04;
    endcase
  endfunction

  // strobe burst B (4 steps)
  function automatic logic [7:0] burst_b(input int j);
    case (j)
      0, 2:    burst_b = 8'h05;
      1:       burst_b = 8'h07;
      default: burst_b = 8'h04;
    endcase
  endfunction
endpackage

// File: rtl/nibseq_prog.sv
module nibseq_prog
  import nibseq_pkg::*;
(
  input  logic [STEP_W-1:0] step_i,
  input  logic              wr_i,
  input  logic              mode_i,
  input  logic [7:0]        idx_i,
  input  logic [7:0]        wdata_i,
  output step_t             step_o,
  output logic              last_o
);
  int s, t;

  always_comb begin
    s = int'(step_i);
    t = s - ADDR_LEN;
    step_o.kind = K_CTRL;
    step_o.val  = CTRL_REST;
    last_o      = 1'b0;
    if (s < ADDR_LEN) begin
      if (s == 0) begin
        step_o.kind = K_DATA; step_o.val = 8'h01;
      end else if (s <= 6) begin
        step_o.val = burst_a(s - 1);
      end else if (s == 7) begin
        step_o.kind = K_DATA; step_o.val = idx_i;
      end else if (s <= 11) begin
        step_o.val = burst_b(s - 8);
      end else if (s == 12) begin
        step_o.kind = K_DATA; step_o.val = 8'h00;
      end else begin
        step_o.val = burst_a(s - 13);
      end
    end else if (wr_i) begin
      last_o = (t == TAIL_WR - 1);
      if (t == 0 || t == 5) begin
        step_o.kind = K_DATA; step_o.val = wdata_i;
      end else begin
        step_o.val = burst_b(t < 5 ? t - 1 : t - 6);
      end
    end else if (!mode_i) begin
      last_o = (t == TAIL_RD4 - 1);
      case (t)
        0, 3, 6, 8: step_o.val = CTRL_NIB;
        1:          step_o.kind = K_SAMP_A;
        4:          step_o.kind = K_SAMP_B;
        default:    step_o.val = CTRL_REST;
      endcase
    end else begin
      last_o = (t == TAIL_RD8 - 1);
      case (t)
        0, 3:    step_o.val = CTRL_BYTE;
        1:       step_o.kind = K_SAMP_A;
        default: step_o.val = CTRL_REST;
      endcase
    end
  end
endmodule

// File: rtl/nibseq_hold.sv
module nibseq_hold #(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic [HOLD_W-1:0] hold_i,
  output logic              expire_o
);
  logic [HOLD_W-1:0] cnt_q;

  assign expire_o = (cnt_q == hold_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_q <= '0;
    else if (restart_i) cnt_q <= '0;
    else if (!expire_o) cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/nibseq_nib.sv
module nibseq_nib (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cap_a_i,
  input  logic       cap_b_i,
  input  logic       mode_i,
  input  logic [7:0] stat_i,
  input  logic [7:0] pdata_i,
  output logic [7:0] byte_o
);
  logic [7:0] a_q, b_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else begin
      if (cap_a_i) a_q <= mode_i ? pdata_i : stat_i;
      if (cap_b_i) b_q <= stat_i;
    end
  end

  // 8-bit: whole byte; 4-bit: upper nibbles, second sample on top
  assign byte_o = mode_i ? a_q : {b_q[7:4], a_q[7:4]};

  p_cap_excl_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(cap_a_i && cap_b_i));
  p_nib_b_only_4bit_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_b_i |-> !mode_i);
endmodule

// File: rtl/nib_ide_seq.sv
module nib_ide_seq
  import nibseq_pkg::*;
#(
  parameter int HOLD_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              wr_i,
  input  logic              sel_i,
  input  logic [2:0]        reg_i,
  input  logic [7:0]        wdata_i,
  input  logic              mode_i,
  input  logic [HOLD_W-1:0] hold_i,
  input  logic [7:0]        stat_i,
  input  logic [7:0]        pdata_i,
  output logic [7:0]        pdata_o,
  output logic [7:0]        pctrl_o,
  output logic [7:0]        rdata_o,
  output logic              busy_o,
  output logic              done_o
);
  logic              busy_q, done_q, wr_q, mode_q, last_q;
  logic [STEP_W-1:0] step_q, nxt_idx;
  logic [7:0]        idx_q, wdata_q, pdata_q, pctrl_q, rdata_q, idx_in;
  logic [HOLD_W-1:0] hold_q;
  step_kind_e        kind_q;
  step_t             nstep;
  logic              nlast, expire, start, adv, fin, load, cap_a, cap_b;
  logic [7:0]        nib_byte;

  assign idx_in  = {3'b000, reg_i, 2'b00} + 8'd1 + {7'd0, sel_i};
  assign start   = !busy_q && req_i;
  assign adv     = busy_q && expire && !last_q;
  assign fin     = busy_q && expire && last_q;
  assign load    = start || adv;
  assign nxt_idx = busy_q ? step_q + 1'b1 : '0;
  assign cap_a   = busy_q && expire && (kind_q == K_SAMP_A);
  assign cap_b   = busy_q && expire && (kind_q == K_SAMP_B);

  nibseq_prog u_prog (
    .step_i (nxt_idx),
    .wr_i   (busy_q ? wr_q : wr_i),
    .mode_i (busy_q ? mode_q : mode_i),
    .idx_i  (busy_q ? idx_q : idx_in),
    .wdata_i(busy_q ? wdata_q : wdata_i),
    .step_o (nstep),
    .last_o (nlast)
  );

  nibseq_hold #(.HOLD_W(HOLD_W)) u_hold (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .restart_i(load),
    .hold_i   (hold_q),
    .expire_o (expire)
  );

  nibseq_nib u_nib (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .cap_a_i(cap_a),
    .cap_b_i(cap_b),
    .mode_i (mode_q),
    .stat_i (stat_i),
    .pdata_i(pdata_i),
    .byte_o (nib_byte)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      wr_q    <= 1'b0;
      mode_q  <= 1'b0;
      last_q  <= 1'b0;
      step_q  <= '0;
      kind_q  <= K_CTRL;
      idx_q   <= '0;
      wdata_q <= '0;
      hold_q  <= '0;
      pdata_q <= '0;
      pctrl_q <= CTRL_REST;
      rdata_q <= '0;
    end else begin
      done_q <= fin;
      if (start) begin
        busy_q  <= 1'b1;
        wr_q    <= wr_i;
        mode_q  <= mode_i;
        idx_q   <= idx_in;
        wdata_q <= wdata_i;
        hold_q  <= hold_i;
      end
      if (load) begin
        step_q <= nxt_idx;
        kind_q <= nstep.kind;
        last_q <= nlast;
        if (nstep.kind == K_DATA) pdata_q <= nstep.val;
        if (nstep.kind == K_CTRL) pctrl_q <= nstep.val;
      end
      if (fin) begin
        busy_q <= 1'b0;
        if (!wr_q) rdata_q <= nib_byte;
      end
    end
  end

  assign pdata_o = pdata_q;
  assign pctrl_o = pctrl_q;
  assign rdata_o = rdata_q;
  assign busy_o  = busy_q;
  assign done_o  = done_q;

  p_idle_rest_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> pctrl_q == CTRL_REST);
  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  p_done_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  p_busy_held_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !(expire && last_q) |=> busy_q);
  p_hold_stable_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !expire |=> $stable(pctrl_q) && $stable(pdata_q));
  p_ctrl_legal_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pctrl_q inside {8'h04, 8'h05, 8'h06, 8'h07, 8'h0D, 8'h26});
  p_wr_keeps_rdata_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && wr_q |-> $stable(rdata_q));
endmodule

// File: tb/nib_ide_seq_bench.sv
module nib_ide_seq_bench;
  localparam int HW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req = 1'b0, wr = 1'b0, sel = 1'b0, mode = 1'b0;
  logic [2:0]    rg = '0;
  logic [7:0]    wdat = '0;
  logic [HW-1:0] hold = '0;
  logic [7:0]    stat, pdin, pdata, pctrl, rdata;
  logic          busy, done;

  always #4 clk = ~clk;

  nib_ide_seq #(.HOLD_W(HW)) u_nib_ide_seq (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .sel_i(sel),
    .reg_i(rg), .wdata_i(wdat), .mode_i(mode), .hold_i(hold),
    .stat_i(stat), .pdata_i(pdin), .pdata_o(pdata), .pctrl_o(pctrl),
    .rdata_o(rdata), .busy_o(busy), .done_o(done)
  );

  int checks = 0, fails = 0;
  bit ended = 0;

  // adapter model: distinct values per strobe entry
  logic [7:0] sa, sb, sbyte, prev_c;
  int n6, n26;
  assign stat = (n6 == 1) ? sa : (n6 == 2) ? sb : ~sa;
  assign pdin = (n26 == 1) ? sbyte : ~sbyte;

  always @(negedge clk) begin
    if (pctrl == 8'h06 && prev_c != 8'h06) n6 = n6 + 1;
    if (pctrl == 8'h26 && prev_c != 8'h26) n26 = n26 + 1;
    prev_c = pctrl;
  end

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected step list
  logic [7:0] ec[0:31], ed[0:31];
  int en;
  logic [7:0] cur_c = 8'h04, cur_d = 8'h00, exp_rd = 8'h00;

  task automatic push();
    ec[en] = cur_c; ed[en] = cur_d; en++;
  endtask
  task automatic put_d(input logic [7:0] v); cur_d = v; push(); endtask
  task automatic put_c(input logic [7:0] v); cur_c = v; push(); endtask
  task automatic burst_a();
    logic [7:0] a[6] = '{8'h05, 8'h0D, 8'h05, 8'h0D, 8'h05, 8'h04};
    for (int i = 0; i < 6; i++) put_c(a[i]);
  endtask
  task automatic burst_b();
    logic [7:0] b[4] = '{8'h05, 8'h07, 8'h05, 8'h04};
    for (int i = 0; i < 4; i++) put_c(b[i]);
  endtask

  task automatic run(input bit w, input bit s, input logic [2:0] r, input bit m,
                     input logic [HW-1:0] h, input logic [7:0] v, input bit stray, input int t);
    logic [7:0] idx, seen_idx, bad_c, bad_d, bad_k;
    int hc, bad;
    idx = 8'(int'(r) * 4 + 1 + int'(s));
    en = 0;
    put_d(8'h01); burst_a(); put_d(idx); burst_b(); put_d(8'h00); burst_a();
    if (w) begin
      put_d(v); burst_b(); put_d(v); burst_b();
    end else if (!m) begin
      put_c(8'h06); push(); put_c(8'h04); put_c(8'h06); push(); put_c(8'h04);
      put_c(8'h06); put_c(8'h04); put_c(8'h06); put_c(8'h04);
    end else begin
      put_c(8'h26); push(); put_c(8'h04); put_c(8'h26); put_c(8'h04);
    end
    sa = 8'(t * 29 + 8'h1B); sb = 8'(t * 53 + 8'h86); sbyte = 8'(t * 71 + 5);
    if (!w) exp_rd = m ? sbyte : {sb[7:4], sa[7:4]};
    hc = int'(h) + 1;
    // drive request
    wr = w; sel = s; rg = r; mode = m; hold = h; wdat = v;
    n6 = 0; n26 = 0; req = 1'b1;
    @(negedge clk); req = 1'b0;
    bad = 0; seen_idx = 8'hXX; bad_c = 0; bad_d = 0; bad_k = 0;
    for (int j = 0; j < en * hc; j++) begin
      if (j > 0) @(negedge clk);
      if (j / hc == 7) seen_idx = pdata;
      if (stray && j == 2) begin
        req = 1'b1; wr = ~w; mode = ~m; rg = ~r;
      end else req = 1'b0;
      if (bad == 0 && (pctrl !== ec[j / hc] || pdata !== ed[j / hc] || busy !== 1'b1 || done !== 1'b0)) begin
        bad = 1; bad_c = pctrl; bad_d = pdata; bad_k = 8'(j / hc);
      end
    end
    chk(bad == 0, $sformatf("R3/R2/R8 sequence step %0d ctrl", bad_k), bad_c, ec[bad_k]);
    if (bad != 0) $display("  data at mismatch %h expected %h", bad_d, ed[bad_k]);
    chk(seen_idx === idx, "R1 index byte", seen_idx, idx);
    @(negedge clk); req = 1'b0;
    chk(done === 1'b1 && busy === 1'b0, "R9 done pulse with busy low", {6'd0, done, busy}, 8'h02);
    if (w) chk(rdata === exp_rd, "R12 write leaves rdata", rdata, exp_rd);
    else if (m) chk(rdata === exp_rd, "R6 byte read", rdata, exp_rd);
    else chk(rdata === exp_rd, "R5 nibble assembly", rdata, exp_rd);
    @(negedge clk);
    chk(done === 1'b0 && busy === 1'b0, stray ? "R10 stray request ignored" : "R9 done one cycle",
        {6'd0, done, busy}, 8'h00);
  endtask

  initial begin
    prev_c = 8'h04; n6 = 0; n26 = 0; sa = 0; sb = 0; sbyte = 0;
    repeat (3) @(negedge clk);
    chk(pctrl === 8'h04 && pdata === 8'h00, "R11 reset ports", pctrl, 8'h04);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy === 0 && done === 0 && rdata === 0 && pctrl === 8'h04, "R11 idle after reset",
        {5'd0, busy, done, |rdata}, 8'h00);
    begin
      int t = 0;
      logic [HW-1:0] hs[3] = '{4'd0, 4'd1, 4'd3};
      for (int hi = 0; hi < 3; hi++)
        for (int m = 0; m < 2; m++)
          for (int w = 0; w < 2; w++)
            for (int s = 0; s < 2; s++)
              for (int r = 0; r < 8; r++) begin
                // R4 R7 exercised via mode/direction sweep
                run(w[0], s[0], r[2:0], m[0], hs[hi], 8'(t * 37 + 9), (t % 5) == 2, t);
                t++;
                if ((t % 3) == 0) @(negedge clk);
              end
    end
    if (!ended) begin
      ended = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!ended) begin
      ended = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule